// File: doc/BRIEF.md
# Latching Overcurrent Alert Controller

This block raises an active-low, latching alert when a supply rail draws too much current. Three independent causes can set the alert: a digital trip computed from a stream of 12-bit current conversion codes checked against a programmable 8-bit threshold, a level from an external analog comparator, and a software-off request. Each cause has its own sticky flag. The alert output stays driven until software clears the flags through the enable register.

Software writes three registers through a simple write strobe with a select and a data byte: an enable register, a threshold register and a control register. Current codes arrive on a valid/ready stream. The block never applies back-pressure: `code_ready` is held high, and a code is taken on every cycle in which `code_valid` is high. A 6-bit status vector reports the flags and the live comparator level. The alert is modelled as an open-drain enable, where 1 means the pin is pulled low.

Top module: `ocp_alert_ctrl`

## Requirements
- R1: After reset the alert is not driven, every status bit except the live comparator bit (bit 2) is 0, and the threshold register holds 0xFF.
- R2: With enable bit 0 set, a single accepted code whose bits [11:4] are strictly greater than the threshold sets ADC_ALERT (status bit 1) at the clock edge that accepts the code. A code equal to the threshold does not set it.
- R3: With enable bit 1 set, ADC_ALERT is set only by the fourth consecutive accepted code above the threshold. Any accepted code at or below the threshold restarts the count.
- R4: Status bit 0 shows whether the most recently accepted code was above the threshold, and it changes only on accepted codes.
- R5: Status bit 2 follows the comparator input. While enable bit 2 is set and the comparator is high, OC_ALERT (status bit 3) is set at the next edge.
- R6: Writing control bit 0 sets OFF_STATUS (status bit 4) to the written value. While OFF_STATUS and enable bit 3 are both 1, OFF_ALERT (status bit 5) is set at the next edge.
- R7: The alert output is driven exactly when ADC_ALERT, OC_ALERT or OFF_ALERT is set, and it stays driven after its cause goes away.
- R8: A write to the enable register with bit 4 set clears ADC_ALERT, OC_ALERT and OFF_ALERT at that edge, even if a cause is active. Bit 4 is not retained, so a flag whose cause persists sets again on the following edge.
- R9: `code_ready` is always 1, and a code presented while `code_valid` is low has no effect.
- R10: Register select 0 addresses the enable register, 1 the threshold register and 2 the control register. A write with select 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_sel | input | 2 | Register select: 0 enable, 1 threshold, 2 control |
| cfg_wr_data | input | 8 | Register write data |
| cmp_over | input | 1 | External comparator overcurrent level |
| code_valid | input | 1 | Current code valid |
| code_ready | output | 1 | Current code ready (always 1) |
| code_data | input | 12 | Current conversion code |
| alert_od_en | output | 1 | Alert pull-down enable (1 = pin driven low) |
| status | output | 6 | {OFF_ALERT, OFF_STATUS, OC_ALERT, OC live, ADC_ALERT, ADC_OC} |

## Verification
The hardest case to reach is a clear write that lands on the same edge as an active cause. There, the clear must win for one cycle and the flag must then set again, with no further stimulus. The stimulus reaches this state in two ways. It saturates the run counter with more than four codes above the threshold and then issues a clear. It also holds the comparator high through a clear write, and it checks status both on the write's edge and on the edge that follows.

// File: rtl/ocp_alert_pkg.sv
package ocp_alert_pkg;

  typedef enum logic [1:0] {
    SEL_ENABLE  = 2'd0,
    SEL_THRESH  = 2'd1,
    SEL_CONTROL = 2'd2,
    SEL_NONE    = 2'd3
  } reg_sel_e;

  // enable register bit positions
  localparam int EN_SINGLE = 0;
  localparam int EN_QUAD   = 1;
  localparam int EN_CMP    = 2;
  localparam int EN_ARM    = 3;
  localparam int EN_CLEAR  = 4;
  localparam int EN_KEEP_W = 4;

  // sticky flag indices
  localparam int FLG_ADC = 0;
  localparam int FLG_CMP = 1;
  localparam int FLG_OFF = 2;
  localparam int FLG_N   = 3;

  typedef struct packed {
    logic off_alert;
    logic off_status;
    logic oc_alert;
    logic oc_live;
    logic adc_alert;
    logic adc_oc;
  } status_t;

endpackage

// File: rtl/ocp_cfg_regs.sv
module ocp_cfg_regs
  import ocp_alert_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] THR_RESET = '1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [1:0]           wr_sel,
  input  logic [DATA_W-1:0]    wr_data,
  output logic [EN_KEEP_W-1:0] en_q,
  output logic [DATA_W-1:0]    thr_q,
  output logic                 swoff_q,
  output logic                 clr_pulse
);

  logic wr_enable, wr_thresh, wr_control;
  logic unused_data_bits;

  assign wr_enable  = wr_en && (wr_sel == SEL_ENABLE);
  assign wr_thresh  = wr_en && (wr_sel == SEL_THRESH);
  assign wr_control = wr_en && (wr_sel == SEL_CONTROL);

  // clear acts only in the write cycle, so it is never stored
  assign clr_pulse = wr_enable && wr_data[EN_CLEAR];

  assign unused_data_bits = ^wr_data[DATA_W-1:EN_CLEAR];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '0;
      thr_q   <= THR_RESET;
      swoff_q <= 1'b0;
    end else begin
      if (wr_enable)  en_q    <= wr_data[EN_KEEP_W-1:0];
      if (wr_thresh)  thr_q   <= wr_data;
      if (wr_control) swoff_q <= wr_data[0];
    end
  end

endmodule

// File: rtl/ocp_adc_trip.sv
module ocp_adc_trip #(
  parameter int CODE_W  = 12,
  parameter int THR_W   = 8,
  parameter int RUN_LEN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  input  logic [CODE_W-1:0] smp_code,
  input  logic [THR_W-1:0]  thr,
  input  logic              en_single,
  input  logic              en_quad,
  output logic              trip,
  output logic              over_q
);

  localparam int CNT_W = $clog2(RUN_LEN + 1);
  localparam logic [CNT_W-1:0] RUN_MAX  = CNT_W'(RUN_LEN);
  localparam logic [CNT_W-1:0] RUN_LAST = CNT_W'(RUN_LEN - 1);

  logic [THR_W-1:0] code_top;
  logic             over;
  logic [CNT_W-1:0] run_cnt;
  logic             run_done;

  assign code_top = smp_code[CODE_W-1 -: THR_W];
  assign over     = code_top > thr;
  assign run_done = run_cnt >= RUN_LAST;
  assign trip     = smp_valid && over && (en_single || (en_quad && run_done));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt <= '0;
      over_q  <= 1'b0;
    end else if (smp_valid) begin
      over_q <= over;
      if (!over)                 run_cnt <= '0;
      else if (run_cnt != RUN_MAX) run_cnt <= run_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/ocp_sticky_flags.sv
module ocp_sticky_flags #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_vec,
  input  logic         clr,
  output logic [N-1:0] flag_q
);

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          flag_q[i] <= 1'b0;
      else if (clr)        flag_q[i] <= 1'b0;
      else if (set_vec[i]) flag_q[i] <= 1'b1;
    end
  end

endmodule

// File: rtl/ocp_alert_ctrl.sv
module ocp_alert_ctrl
  import ocp_alert_pkg::*;
#(
  parameter int CODE_W  = 12,
  parameter int THR_W   = 8,
  parameter int RUN_LEN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [1:0]        cfg_wr_sel,
  input  logic [THR_W-1:0]  cfg_wr_data,
  input  logic              cmp_over,
  input  logic              code_valid,
  output logic              code_ready,
  input  logic [CODE_W-1:0] code_data,
  output logic              alert_od_en,
  output logic [5:0]        status
);

  logic [EN_KEEP_W-1:0] en_q;
  logic [THR_W-1:0]     thr_q;
  logic                 swoff_q;
  logic                 clr_pulse;
  logic                 adc_trip;
  logic                 adc_over_q;
  logic [FLG_N-1:0]     set_vec;
  logic [FLG_N-1:0]     flag_q;
  status_t              st;

  ocp_cfg_regs #(.DATA_W(THR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (cfg_wr_en),
    .wr_sel    (cfg_wr_sel),
    .wr_data   (cfg_wr_data),
    .en_q      (en_q),
    .thr_q     (thr_q),
    .swoff_q   (swoff_q),
    .clr_pulse (clr_pulse)
  );

  ocp_adc_trip #(.CODE_W(CODE_W), .THR_W(THR_W), .RUN_LEN(RUN_LEN)) u_trip (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_valid (code_valid),
    .smp_code  (code_data),
    .thr       (thr_q),
    .en_single (en_q[EN_SINGLE]),
    .en_quad   (en_q[EN_QUAD]),
    .trip      (adc_trip),
    .over_q    (adc_over_q)
  );

  assign set_vec[FLG_ADC] = adc_trip;
  assign set_vec[FLG_CMP] = en_q[EN_CMP] && cmp_over;
  assign set_vec[FLG_OFF] = en_q[EN_ARM] && swoff_q;

  ocp_sticky_flags #(.N(FLG_N)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (set_vec),
    .clr     (clr_pulse),
    .flag_q  (flag_q)
  );

  assign code_ready  = 1'b1;
  assign alert_od_en = |flag_q;

  always_comb begin
    st.adc_oc     = adc_over_q;
    st.adc_alert  = flag_q[FLG_ADC];
    st.oc_live    = cmp_over;
    st.oc_alert   = flag_q[FLG_CMP];
    st.off_status = swoff_q;
    st.off_alert  = flag_q[FLG_OFF];
  end
  assign status = st;

endmodule

// File: rtl/ocp_alert_chk.sv
module ocp_alert_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_wr_en,
  input logic [1:0]  cfg_wr_sel,
  input logic [7:0]  cfg_wr_data,
  input logic        cmp_over,
  input logic        code_valid,
  input logic        alert_od_en,
  input logic [5:0]  status,
  input logic [3:0]  en_q
);

  logic clr_w;
  assign clr_w = cfg_wr_en && (cfg_wr_sel == 2'd0) && cfg_wr_data[4];

  // R1: quiet while reset is held
  always @(posedge clk) begin
    if (!rst_n) a_r1_quiet_in_reset: assert (!alert_od_en && status[5:3] == 3'b000 && status[1] == 1'b0);
  end

  // R7: alert is sticky until a clear write
  a_r7_alert_holds: assert property (@(posedge clk) disable iff (!rst_n)
    alert_od_en && !clr_w |=> alert_od_en);

  // R8: a clear write empties all three flags at its edge
  a_r8_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clr_w |=> (!status[1] && !status[3] && !status[5] && !alert_od_en));

  // R5: enabled comparator level latches OC_ALERT
  a_r5_cmp_latches: assert property (@(posedge clk) disable iff (!rst_n)
    en_q[2] && cmp_over && !clr_w |=> status[3]);

  // R6: writing the software-off bit sets OFF_STATUS
  a_r6_swoff_status: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr_en && cfg_wr_sel == 2'd2 && cfg_wr_data[0] |=> status[4]);

  // R2: no digital trip while both digital enables are off
  a_r2_no_trip_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    code_valid && en_q[1:0] == 2'b00 && !status[1] |=> !status[1]);

endmodule

bind ocp_alert_ctrl ocp_alert_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_wr_en   (cfg_wr_en),
  .cfg_wr_sel  (cfg_wr_sel),
  .cfg_wr_data (cfg_wr_data),
  .cmp_over    (cmp_over),
  .code_valid  (code_valid),
  .alert_od_en (alert_od_en),
  .status      (status),
  .en_q        (en_q)
);

// File: tb/sim_ocp_alert_ctrl.sv
module sim_ocp_alert_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [1:0]  cfg_wr_sel = 2'd0;
  logic [7:0]  cfg_wr_data = 8'h00;
  logic        cmp_over = 1'b0;
  logic        code_valid = 1'b0;
  logic        code_ready;
  logic [11:0] code_data = 12'h000;
  logic        alert_od_en;
  logic [5:0]  status;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ocp_alert_ctrl u0 (
    .clk (clk), .rst_n (rst_n), .cfg_wr_en (cfg_wr_en), .cfg_wr_sel (cfg_wr_sel),
    .cfg_wr_data (cfg_wr_data), .cmp_over (cmp_over), .code_valid (code_valid),
    .code_ready (code_ready), .code_data (code_data), .alert_od_en (alert_od_en),
    .status (status)
  );

  // we, sel, data, valid, code, cmp, expected status, requirement
  typedef struct packed {
    logic        we;
    logic [1:0]  sel;
    logic [7:0]  wd;
    logic        cv;
    logic [11:0] code;
    logic        cmp;
    logic [5:0]  exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 39;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 2'd1, 8'h80, 1'b0, 12'h000, 1'b0, 6'h00, 4'd10}, // R10 threshold 0x80
    '{1'b1, 2'd0, 8'h01, 1'b0, 12'h000, 1'b0, 6'h00, 4'd2},  // R2 single enable
    '{1'b0, 2'd0, 8'h00, 1'b1, 12'h800, 1'b0, 6'h00, 4'd2},  // R2 equal: no trip
    '{1'b0, 2'd0, 8'h00, 1'b1, 12'h810, 1'b0, 6'h03, 4'd2},  // R2 above: trip
    '{1'b0, 2'd0, 8'h00, 1'b0, 12'h000, 1'b0, 6'h03, 4'd4},  // R4 held without sample
    '{1'b0, 2'd0, 8'h00, 1'b1, 12'h100, 1'b0, 6'h02, 4'd7},  // R7 alert sticks
    '{1'b1, 2'd0, 8'h10, 1'b0, 12'h000, 1'b0, 6'h00, 4'd8},  // R8 clear
    '{1'b1, 2'd0, 8'h02, 1'b0, 12'h000, 1'b0, 6'h00, 4'd3},  // R3 quad enable
    '{1'b0, 2'd0, 8'h00, 1'b1, 12'h900, 1'b0, 6'h01, 4'd3},
    '{1'b0, 2'd0, 8'h00, 1'b1, 12'h900, 1'b0, 6'h01, 4'd3},
    '{1'b0, 2'd0, 8'h00, 1'b1, 12'h7F0, 1'b0, 6'h00, 4'd3},  // R3 restart count
    '{1'b0, 2'd0, 8'h00, 1'b1, 12'h900, 1'b0, 6'h01, 4'd3},
    '{1'b0, 2'd0, 8'h00, 1'b1, 12'h900, 1'b0, 6'h01, 4'd3},
    '{1'b0, 2'd0, 8'h00, 1'b1, 12'h900, 1'b0, 6'h01, 4'd3},
    '{1'b0, 2'd0, 8'h00, 1'b1, 12'h900, 1'b0, 6'h03, 4'd3},  // R3 fourth trips
    '{1'b0, 2'd0, 8'h00, 1'b1, 12'h900, 1'b0, 6'h03, 4'd3},
    '{1'b1, 2'd0, 8'h12, 1'b0, 12'h000, 1'b0, 6'h01, 4'd8},  // R8 clear, keep quad
    '{1'b0, 2'd0, 8'h00, 1'b1, 12'h900, 1'b0, 6'h03, 4'd8},  // R8 re-sets
    '{1'b1, 2'd0, 8'h10, 1'b0, 12'h000, 1'b0, 6'h01, 4'd8},
    '{1'b0, 2'd0, 8'h00, 1'b0, 12'h000, 1'b1, 6'h05, 4'd5},  // R5 live, no latch
    '{1'b1, 2'd0, 8'h04, 1'b0, 12'h000, 1'b1, 6'h05, 4'd5},
    '{1'b0, 2'd0, 8'h00, 1'b0, 12'h000, 1'b1, 6'h0D, 4'd5},  // R5 latched
    '{1'b0, 2'd0, 8'h00, 1'b0, 12'h000, 1'b0, 6'h09, 4'd7},  // R7 sticky
    '{1'b1, 2'd0, 8'h14, 1'b0, 12'h000, 1'b0, 6'h01, 4'd8},
    '{1'b0, 2'd0, 8'h00, 1'b0, 12'h000, 1'b1, 6'h0D, 4'd5},
    '{1'b1, 2'd0, 8'h14, 1'b0, 12'h000, 1'b1, 6'h05, 4'd8},  // R8 clear wins
    '{1'b0, 2'd0, 8'h00, 1'b0, 12'h000, 1'b1, 6'h0D, 4'd8},  // R8 re-sets
    '{1'b1, 2'd0, 8'h10, 1'b0, 12'h000, 1'b0, 6'h01, 4'd8},
    '{1'b1, 2'd2, 8'h01, 1'b0, 12'h000, 1'b0, 6'h11, 4'd6},  // R6 not armed
    '{1'b1, 2'd0, 8'h08, 1'b0, 12'h000, 1'b0, 6'h11, 4'd6},
    '{1'b0, 2'd0, 8'h00, 1'b0, 12'h000, 1'b0, 6'h31, 4'd6},  // R6 armed
    '{1'b1, 2'd2, 8'h00, 1'b0, 12'h000, 1'b0, 6'h21, 4'd6},
    '{1'b1, 2'd0, 8'h18, 1'b0, 12'h000, 1'b0, 6'h01, 4'd8},
    '{1'b1, 2'd3, 8'hFF, 1'b0, 12'h000, 1'b0, 6'h01, 4'd10}, // R10 select 3 ignored
    '{1'b0, 2'd0, 8'h00, 1'b1, 12'h000, 1'b0, 6'h00, 4'd4},  // R4
    '{1'b1, 2'd1, 8'h00, 1'b0, 12'h000, 1'b0, 6'h00, 4'd10},
    '{1'b1, 2'd0, 8'h01, 1'b0, 12'h000, 1'b0, 6'h00, 4'd2},
    '{1'b0, 2'd0, 8'h00, 1'b1, 12'h00F, 1'b0, 6'h00, 4'd2},  // R2 equal at zero
    '{1'b0, 2'd0, 8'h00, 1'b1, 12'h010, 1'b0, 6'h03, 4'd2}
  };

  task automatic chk(input int req, input logic [7:0] act, input logic [7:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic we, input logic [1:0] sel, input logic [7:0] wd,
                       input logic cv, input logic [11:0] code, input logic cmp);
    cfg_wr_en = we; cfg_wr_sel = sel; cfg_wr_data = wd;
    code_valid = cv; code_data = code; cmp_over = cmp;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    do_reset();
    // R1 reset state
    chk(1, {2'b0, status}, 8'h00, "reset status");
    chk(1, {7'b0, alert_od_en}, 8'h00, "reset alert");

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i].we, VEC[i].sel, VEC[i].wd, VEC[i].cv, VEC[i].code, VEC[i].cmp);
      @(negedge clk);
      chk(VEC[i].req, {2'b0, status}, {2'b0, VEC[i].exp}, $sformatf("vector %0d status", i));
      chk(7, {7'b0, alert_od_en}, {7'b0, VEC[i].exp[1] | VEC[i].exp[3] | VEC[i].exp[5]},
          $sformatf("vector %0d alert", i));
    end
    drive(1'b0, 2'd0, 8'h00, 1'b0, 12'h000, 1'b0);

    // R1 threshold resets to 0xFF: code 0xFFF does not trip
    do_reset();
    drive(1'b1, 2'd0, 8'h01, 1'b0, 12'h000, 1'b0);
    @(negedge clk);
    drive(1'b0, 2'd0, 8'h00, 1'b1, 12'hFFF, 1'b0);
    // R9 ready while valid
    chk(9, {7'b0, code_ready}, 8'h01, "ready with valid");
    @(negedge clk);
    chk(1, {2'b0, status}, 8'h00, "default threshold 0xFF");

    // R9 code without valid is ignored
    drive(1'b1, 2'd1, 8'h00, 1'b0, 12'h000, 1'b0);
    @(negedge clk);
    drive(1'b0, 2'd0, 8'h00, 1'b0, 12'hFFF, 1'b0);
    repeat (3) @(negedge clk);
    chk(9, {2'b0, status}, 8'h00, "code without valid");
    chk(9, {7'b0, alert_od_en}, 8'h00, "alert without valid");

    // R1 reset drops a raised alert
    drive(1'b0, 2'd0, 8'h00, 1'b1, 12'hFFF, 1'b0);
    @(negedge clk);
    drive(1'b0, 2'd0, 8'h00, 1'b0, 12'h000, 1'b0);
    chk(2, {7'b0, alert_od_en}, 8'h01, "alert raised before reset");
    do_reset();
    chk(1, {7'b0, alert_od_en}, 8'h00, "alert after reset");
    chk(1, {2'b0, status}, 8'h00, "status after reset");

    finish_run();
  end

endmodule